// File: doc/BRIEF.md
# Dual-Button Delayed Reset Generator

This block turns two ordinary keys into a hardware reset source. A reset is issued only after both active-low key inputs have been held down together, with no break, for a selectable setup time of 2, 6 or 10 seconds. Letting go of either key before the time is up discards the attempt, and the count starts again from zero at the next joint press. Time is measured in pulses of a tick-enable input, nominally 1 kHz.

Once the setup time has elapsed the active-low reset output is driven. In pulse mode it is held for a fixed recovery time (200 ms by default) and then released. In follow mode it stays low for as long as both keys stay down. In either mode the keys must both be released before a new attempt can start, so a held pair of keys yields one reset. An undervoltage input pulls reset low at once, overriding the key logic, and reset is released only after a full recovery time once the input clears. The block's own asynchronous reset behaves the same way. Two further outputs show when both keys are down and when either key is down. The second can serve as an early interrupt that warns software before a reset arrives.

Top module: `dual_btn_reset`

## Requirements
- R1: `rst_no_o` falls only after both keys have been seen pressed without a break for the full setup time. If either key is released sooner, the count is discarded, and a new joint press must again last the full setup time.
- R2: With `tick_i` high every cycle, `rst_no_o` falls on the clock edge 3 + T after the edge on which both keys are first driven low. T is 2000 ticks for `dly_sel_i` = 2'b00, 6000 for 2'b01, and 10000 for both 2'b10 and 2'b11.
- R3: With `hold_mode_i` = 0, `rst_no_o` stays low for exactly REC_TICKS (200) ticks after it falls, then goes high, even while the keys are still held.
- R4: With `hold_mode_i` = 1, `rst_no_o` stays low while both keys stay pressed. It goes high on the third clock edge after one key is released.
- R5: While `uv_i` is high, `rst_no_o` is low within the same cycle. Once `uv_i` goes low, `rst_no_o` stays low for REC_TICKS further ticks and then goes high.
- R6: `both_o` is high exactly when both keys are pressed, as seen through a two-stage synchroniser (2 clock edges of latency).
- R7: `warn_o` is high when either key is pressed, with the same 2-edge latency and no setup delay.
- R8: After a reset ends, no new setup count starts until both keys have been seen released. Keys held for a further full setup time give no second reset.
- R9: While `rst_ni` is low, `rst_no_o` is low and `both_o` and `warn_o` are low. After `rst_ni` rises, `rst_no_o` stays low for REC_TICKS ticks.
- R10: The setup and recovery counters advance only on clock edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one pulse per tick |
| btn_a_ni | input | 1 | Key A, low when pressed, asynchronous |
| btn_b_ni | input | 1 | Key B, low when pressed, asynchronous |
| dly_sel_i | input | 2 | Setup time select: 00 short, 01 middle, 1x long |
| hold_mode_i | input | 1 | 0: fixed-length reset, 1: reset follows key hold |
| uv_i | input | 1 | Undervoltage indication, forces reset |
| rst_no_o | output | 1 | Reset output, active low |
| both_o | output | 1 | Both keys pressed |
| warn_o | output | 1 | Either key pressed, early warning |

## Verification
Directed joint presses at each of the four select codes confirm the exact edge on which reset falls. Together they separate a correct setup count from one that is off by one, or that decodes the wrong select value. A press that is broken for a few cycles and then resumed shows whether a release restarts the count or only pauses it. A hold kept well past the end of the pulse shows whether a second reset is blocked. Randomised phases mix single-key presses, joint presses of random length, gaps in the tick input, undervoltage pulses and mode changes, and compare every cycle against a bench model. This exercises the interplay of counting, cancellation and the override.

// File: rtl/dual_btn_reset_pkg.sv
package dual_btn_reset_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_REC   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WREL  = 3'd4
  } rst_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_ni,
  output logic [N-1:0] pressed_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= raw_ni;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign pressed_o = ~stg_q[STAGES-1];
endmodule

// File: rtl/setup_sel.sv
module setup_sel #(
  parameter int TICK_HZ     = 1000,
  parameter int DLY_SHORT_S = 2,
  parameter int DLY_MID_S   = 6,
  parameter int DLY_LONG_S  = 10,
  parameter int CNT_W       = 16
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] ticks_o
);
  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(DLY_SHORT_S * TICK_HZ);
  localparam logic [CNT_W-1:0] T_MID   = CNT_W'(DLY_MID_S * TICK_HZ);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(DLY_LONG_S * TICK_HZ);

  always_comb begin
    unique case (sel_i)
      2'b00:   ticks_o = T_SHORT;
      2'b01:   ticks_o = T_MID;
      default: ticks_o = T_LONG;  // reserved code falls back to longest
    endcase
  end
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import dual_btn_reset_pkg::*;
#(
  parameter int REC_TICKS = 200,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             uv_i,
  input  logic             hold_mode_i,
  input  logic [CNT_W-1:0] setup_ticks_i,
  output logic             rst_act_o
);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_TICKS - 1);

  rst_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             both, none;

  assign both = a_i & b_i;
  assign none = ~a_i & ~b_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (uv_i) begin
      st_d  = ST_REC;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (both) begin
          st_d  = ST_SETUP;
          cnt_d = '0;
        end
        ST_SETUP: begin
          if (!both) begin
            st_d = ST_IDLE;
          end else if (tick_i) begin
            if (cnt_q == setup_ticks_i - CNT_W'(1)) begin
              st_d  = hold_mode_i ? ST_HOLD : ST_REC;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_REC: if (tick_i) begin
          if (cnt_q == REC_LAST) begin
            st_d  = ST_WREL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_HOLD: if (!both) st_d = ST_WREL;
        ST_WREL: if (none) st_d = ST_IDLE;
        default: st_d = ST_WREL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_REC;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign rst_act_o = (st_q == ST_REC) || (st_q == ST_HOLD);
endmodule

// File: rtl/dual_btn_reset.sv
module dual_btn_reset #(
  parameter int TICK_HZ     = 1000,
  parameter int DLY_SHORT_S = 2,
  parameter int DLY_MID_S   = 6,
  parameter int DLY_LONG_S  = 10,
  parameter int REC_MS      = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [1:0] dly_sel_i,
  input  logic       hold_mode_i,
  input  logic       uv_i,
  output logic       rst_no_o,
  output logic       both_o,
  output logic       warn_o
);
  localparam int REC_TICKS = (REC_MS * TICK_HZ) / 1000;
  localparam int MAX_TICKS = DLY_LONG_S * TICK_HZ + REC_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [1:0]       pressed;
  logic [CNT_W-1:0] setup_ticks;
  logic             rst_act;

  btn_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_ni    ({btn_b_ni, btn_a_ni}),
    .pressed_o (pressed)
  );

  setup_sel #(
    .TICK_HZ(TICK_HZ), .DLY_SHORT_S(DLY_SHORT_S), .DLY_MID_S(DLY_MID_S),
    .DLY_LONG_S(DLY_LONG_S), .CNT_W(CNT_W)
  ) u_sel (
    .sel_i   (dly_sel_i),
    .ticks_o (setup_ticks)
  );

  rst_seq #(.REC_TICKS(REC_TICKS), .CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .a_i           (pressed[0]),
    .b_i           (pressed[1]),
    .uv_i          (uv_i),
    .hold_mode_i   (hold_mode_i),
    .setup_ticks_i (setup_ticks),
    .rst_act_o     (rst_act)
  );

  // undervoltage bypasses the register stage for an immediate reset
  assign rst_no_o = ~(uv_i | rst_act | ~rst_ni);
  assign both_o   = pressed[0] & pressed[1];
  assign warn_o   = pressed[0] | pressed[1];
endmodule

// File: rtl/dual_btn_reset_chk.sv
module dual_btn_reset_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic uv_i,
  input logic rst_no_o,
  input logic both_o,
  input logic warn_o
);
  // R5
  uv_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !rst_no_o);

  // R7
  both_implies_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_o |-> warn_o);

  // R1
  fall_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_no_o) && !uv_i) |-> $past(both_o));

  // R10
  rise_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no_o) |-> ($past(tick_i) || !$past(both_o)));
endmodule

bind dual_btn_reset dual_btn_reset_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .uv_i     (uv_i),
  .rst_no_o (rst_no_o),
  .both_o   (both_o),
  .warn_o   (warn_o)
);

// File: tb/tb_dual_btn_reset.sv
`timescale 1ns/1ps
module tb_dual_btn_reset;
  localparam int REC = 200;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic btn_a = 1'b1, btn_b = 1'b1;
  logic [1:0] sel = 2'b00;
  logic hold = 1'b0;
  logic uv = 1'b0;
  logic rst_no, both, warn;

  int checks = 0, errors = 0, cyc = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  dual_btn_reset dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .btn_a_ni(btn_a), .btn_b_ni(btn_b),
    .dly_sel_i(sel), .hold_mode_i(hold), .uv_i(uv),
    .rst_no_o(rst_no), .both_o(both), .warn_o(warn)
  );

  function automatic int setup_ticks(input logic [1:0] s);
    case (s)
      2'b00:   return 2000;
      2'b01:   return 6000;
      default: return 10000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench model: 0 idle, 1 setup, 2 recover, 3 hold, 4 wait release
  logic m_s1a, m_s2a, m_s1b, m_s2b;
  int m_st, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1a <= 1; m_s2a <= 1; m_s1b <= 1; m_s2b <= 1;
      m_st <= 2; m_cnt <= 0;
    end else begin
      bit pa, pb;
      pa = !m_s2a; pb = !m_s2b;
      m_s1a <= btn_a; m_s2a <= m_s1a; m_s1b <= btn_b; m_s2b <= m_s1b;
      if (uv) begin m_st <= 2; m_cnt <= 0; end
      else case (m_st)
        0: if (pa && pb) begin m_st <= 1; m_cnt <= 0; end
        1: if (!(pa && pb)) m_st <= 0;
           else if (tick) begin
             if (m_cnt + 1 == setup_ticks(sel)) begin m_st <= hold ? 3 : 2; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
           end
        2: if (tick) begin
             if (m_cnt + 1 == REC) begin m_st <= 4; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
           end
        3: if (!(pa && pb)) m_st <= 4;
        default: if (!pa && !pb) m_st <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit e_rst, e_both, e_warn;
      e_rst  = !(uv || m_st == 2 || m_st == 3);
      e_both = !m_s2a && !m_s2b;
      e_warn = !m_s2a || !m_s2b;
      chk(rst_no == e_rst, "R1", "model rst_no", rst_no, e_rst);
      chk(both == e_both, "R6", "model both_o", both, e_both);
      chk(warn == e_warn, "R7", "model warn_o", warn, e_warn);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic settle();
    btn_a = 1; btn_b = 1; uv = 0; tick = 1;
    wait_cyc(REC + 10);
  endtask

  task automatic setup_timing(input logic [1:0] s, input string req);
    int t;
    t = setup_ticks(s);
    sel = s; hold = 0;
    btn_a = 0; btn_b = 0;
    wait_cyc(2);
    chk(both == 1, "R6", "both_o after 2 edges", both, 1);
    chk(warn == 1, "R7", "warn_o after 2 edges", warn, 1);
    wait_cyc(t);
    chk(rst_no == 1, req, "rst_no one edge before setup end", rst_no, 1);
    wait_cyc(1);
    chk(rst_no == 0, req, "rst_no at setup end", rst_no, 0);
  endtask

  initial begin
    // R9 reset state
    wait_cyc(3);
    chk(rst_no == 0, "R9", "rst_no in reset", rst_no, 0);
    chk(both == 0, "R9", "both_o in reset", both, 0);
    chk(warn == 0, "R9", "warn_o in reset", warn, 0);
    rst_n = 1;
    wait_cyc(REC - 1);
    chk(rst_no == 0, "R9", "rst_no before recovery end", rst_no, 0);
    wait_cyc(1);
    chk(rst_no == 1, "R9", "rst_no after recovery", rst_no, 1);
    wait_cyc(5);

    // R7 single key only warns
    btn_a = 0;
    wait_cyc(2);
    chk(warn == 1, "R7", "warn_o single key", warn, 1);
    chk(both == 0, "R6", "both_o single key", both, 0);
    wait_cyc(2100);
    chk(rst_no == 1, "R1", "single key no reset", rst_no, 1);
    btn_a = 1; wait_cyc(5);

    // R2 + R3 + R8 short setup, fixed pulse, held on
    setup_timing(2'b00, "R2");
    wait_cyc(REC - 1);
    chk(rst_no == 0, "R3", "rst_no last pulse cycle", rst_no, 0);
    wait_cyc(1);
    chk(rst_no == 1, "R3", "rst_no after pulse", rst_no, 1);
    wait_cyc(2100);
    chk(rst_no == 1, "R8", "no re-arm while held", rst_no, 1);
    settle();

    setup_timing(2'b01, "R2");
    settle();
    setup_timing(2'b10, "R2");
    settle();
    setup_timing(2'b11, "R2");
    settle();

    // R1 broken hold restarts the count
    sel = 2'b00; hold = 0;
    btn_a = 0; btn_b = 0;
    wait_cyc(1500);
    btn_b = 1; wait_cyc(4); btn_b = 0;
    wait_cyc(2 + 2000);
    chk(rst_no == 1, "R1", "no reset before fresh count ends", rst_no, 1);
    wait_cyc(1);
    chk(rst_no == 0, "R1", "reset after fresh full count", rst_no, 0);
    settle();

    // R4 follow mode
    hold = 1;
    btn_a = 0; btn_b = 0;
    wait_cyc(3 + 2000);
    chk(rst_no == 0, "R4", "rst_no asserted", rst_no, 0);
    wait_cyc(600);
    chk(rst_no == 0, "R4", "rst_no held past recovery", rst_no, 0);
    btn_a = 1;
    wait_cyc(2);
    chk(rst_no == 0, "R4", "rst_no two edges after release", rst_no, 0);
    wait_cyc(1);
    chk(rst_no == 1, "R4", "rst_no three edges after release", rst_no, 1);
    hold = 0;
    settle();

    // R5 undervoltage override
    uv = 1; #1;
    chk(rst_no == 0, "R5", "rst_no same cycle as uv", rst_no, 0);
    wait_cyc(10);
    uv = 0;
    wait_cyc(REC - 1);
    chk(rst_no == 0, "R5", "rst_no before recovery end", rst_no, 0);
    wait_cyc(1);
    chk(rst_no == 1, "R5", "rst_no after recovery", rst_no, 1);

    // R10 counting follows tick_i only
    uv = 1; wait_cyc(3); uv = 0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 2000; i++) begin
        tick = (i % 3 == 2);
        @(posedge clk);
        if (tick) seen++;
        @(negedge clk);
        if (seen < REC) begin
          if (rst_no != 0) begin chk(0, "R10", "early release", rst_no, 0); break; end
        end else begin
          chk(rst_no == 1, "R10", "release on last tick", rst_no, 1);
          break;
        end
      end
    end
    settle();

    // random phase against bench model
    process_random();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic process_random();
    void'($urandom(32'h5eed_1234));
    sel = 2'b00;
    model_on = 1'b1;
    for (int ep = 0; ep < 40; ep++) begin
      int kind, len;
      kind = $urandom % 8;
      len  = $urandom % 3500;
      if (kind == 0) begin
        uv = 1; len = 1 + $urandom % 20;
      end else if (kind == 1) begin
        btn_a = $urandom % 2; btn_b = 1;
      end else if (kind == 2) begin
        btn_a = 1; btn_b = 1;
        if (m_st == 0) hold = $urandom % 2;
      end else begin
        btn_a = 0; btn_b = 0;
      end
      for (int i = 0; i < len; i++) begin
        tick = ($urandom % 4) != 0;
        if ((kind >= 3) && ($urandom % 1500 == 0)) btn_b = ~btn_b;
        @(negedge clk);
      end
      uv = 0;
    end
    btn_a = 1; btn_b = 1; tick = 1;
    wait_cyc(400);
    model_on = 1'b0;
  endtask
endmodule